// File: doc/BRIEF.md
# Middle Memory Bank Selector

This block chooses, for each flit presented in a cycle, one of `NBANK` shared buffer banks in which the flit waits until its departure cycle. Each flit arrives with a departure timestamp. Two placement rules apply:

- Two flits arriving in the same cycle must never be written to the same bank, because each bank accepts one write per cycle.
- A bank must never hold two flits with the same departure timestamp, because each bank delivers one read per cycle.

With `NPORT` requesters, `2*NPORT-1` banks always leave a legal choice. Fewer banks save area, but then a request can be refused. A refused flit is not lost. The upstream logic gives it a new timestamp and presents it again in a later cycle.

The selector keeps a per-bank occupancy table indexed by timestamp, taken modulo `2**TS_W`. It also keeps a per-bank fill count limited to `DEPTH` entries. A departure input names the timestamp whose flits leave in this cycle. That timestamp is cleared in every bank, which frees the slots it held.

Ports are served in a fixed priority order. Each port takes the lowest-numbered bank that is still eligible. Results are registered and appear one clock after the request. The bank storage itself and the crossbars are outside this block.

Top module: `mm_bank_picker`

## Requirements
- R1: While `rst` is high at a clock edge, every `gnt_ok` bit and every `gnt_bank` field become 0, and the occupancy table and fill counts become empty.
- R2: The result for port p appears on `gnt_ok[p]` and `gnt_bank[p*BI_W +: BI_W]` one clock after `req_vld[p]` is sampled. A port with no request shows `gnt_ok[p]=0` and bank field 0.
- R3: In any cycle, no two ports with `gnt_ok=1` carry the same bank index.
- R4: A bank that already holds an entry with the request's timestamp is not eligible for it. No bank ever records the same timestamp twice.
- R5: Ports are served in ascending order, port 0 first. Each port takes the lowest-indexed eligible bank, and that bank becomes ineligible for the later ports in the same cycle.
- R6: A bank that holds `DEPTH` entries is not eligible.
- R7: When no bank is eligible, the port shows `gnt_ok=0` with bank field 0 and nothing is recorded. The same flit can be granted in a later cycle once a bank becomes eligible.
- R8: When `dep_vld` is high, timestamp `dep_ts` is cleared in every bank and each bank that held it gets one slot back. The change is visible to requests sampled in the next cycle.
- R9: A request whose timestamp equals `dep_ts` while `dep_vld` is high is refused in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | NPORT | Per-port request valid |
| req_ts | input | NPORT*TS_W | Per-port departure timestamp; port p uses bits [p*TS_W +: TS_W] |
| dep_vld | input | 1 | A departure timestamp is read out this cycle |
| dep_ts | input | TS_W | Departing timestamp |
| gnt_ok | output | NPORT | Registered per-port success flag |
| gnt_bank | output | NPORT*BI_W | Registered per-port bank index; port p uses bits [p*BI_W +: BI_W] |

## Verification
The hardest condition to reach from the ports is a refusal caused only by capacity. This is a bank that is full while holding none of the requested timestamps, with the other banks blocked by timestamp clashes. The stimulus first fills bank 0 with distinct timestamps through single requests. It then sends a request that must skip bank 0 and go to bank 1. A long random phase follows, using a narrow timestamp range and sparse departures, so that fill-limited and clash-limited refusals both occur many times. A behavioural model in the bench tracks the expected table on every cycle.

// File: rtl/mmsel_pkg.sv
package mmsel_pkg;
  // width of an index into n items (at least one bit)
  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // width of a counter that must reach the value lim
  function automatic int unsigned cnt_width(input int unsigned lim);
    return $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/mm_bank_track.sv
module mm_bank_track #(
  parameter int NPORT = 5,
  parameter int TS_W  = 4,
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPORT*TS_W-1:0] q_ts,
  output logic [NPORT-1:0]      hit,
  output logic                  full,
  input  logic                  set_en,
  input  logic [TS_W-1:0]       set_ts,
  input  logic                  clr_en,
  input  logic [TS_W-1:0]       clr_ts
);
  import mmsel_pkg::*;
  localparam int SLOTS = 2 ** TS_W;
  localparam int CW    = cnt_width(DEPTH);

  logic [SLOTS-1:0] occ, occ_nxt;
  logic [CW-1:0]    cnt, cnt_nxt;
  logic             clr_hit;

  always_comb begin
    for (int p = 0; p < NPORT; p++) hit[p] = occ[q_ts[p*TS_W +: TS_W]];
  end

  assign full    = (cnt == CW'(DEPTH));
  assign clr_hit = clr_en && occ[clr_ts];

  always_comb begin
    occ_nxt = occ;
    if (clr_en) occ_nxt[clr_ts] = 1'b0;
    if (set_en) occ_nxt[set_ts] = 1'b1;
    cnt_nxt = cnt + CW'(set_en) - CW'(clr_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
      cnt <= '0;
    end else begin
      occ <= occ_nxt;
      cnt <= cnt_nxt;
    end
  end

  assert_no_dup_ts_R4: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !occ[set_ts]);
  assert_no_overfill_R6: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !full);
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  assert_clear_done_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(set_en && set_ts == clr_ts)) |=> !occ[$past(clr_ts)]);
endmodule

// File: rtl/mm_pick_chain.sv
module mm_pick_chain #(
  parameter int NPORT = 5,
  parameter int NBANK = 5,
  parameter int TS_W  = 4,
  parameter int BI_W  = 3
) (
  input  logic [NPORT-1:0]       req_vld,
  input  logic [NPORT*TS_W-1:0]  req_ts,
  input  logic [NPORT*NBANK-1:0] hit,
  input  logic [NBANK-1:0]       full,
  input  logic                   dep_vld,
  input  logic [TS_W-1:0]        dep_ts,
  output logic [NPORT-1:0]       ok,
  output logic [NPORT*BI_W-1:0]  bank
);
  logic [NBANK-1:0] taken;

  // ports resolve in ascending priority; each claims the lowest free bank
  always_comb begin
    taken = '0;
    ok    = '0;
    bank  = '0;
    for (int p = 0; p < NPORT; p++) begin
      logic found;
      found = 1'b0;
      if (req_vld[p] && !(dep_vld && dep_ts == req_ts[p*TS_W +: TS_W])) begin
        for (int b = 0; b < NBANK; b++) begin
          if (!found && !hit[p*NBANK + b] && !full[b] && !taken[b]) begin
            found                  = 1'b1;
            ok[p]                  = 1'b1;
            bank[p*BI_W +: BI_W]   = BI_W'(b);
            taken[b]               = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mm_bank_picker.sv
module mm_bank_picker #(
  parameter int NPORT = 5,
  parameter int NBANK = 5,
  parameter int TS_W  = 4,
  parameter int DEPTH = 4,
  parameter int BI_W  = mmsel_pkg::idx_width(NBANK)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPORT-1:0]      req_vld,
  input  logic [NPORT*TS_W-1:0] req_ts,
  input  logic                  dep_vld,
  input  logic [TS_W-1:0]       dep_ts,
  output logic [NPORT-1:0]      gnt_ok,
  output logic [NPORT*BI_W-1:0] gnt_bank
);
  logic [NPORT*NBANK-1:0] hit;
  logic [NBANK-1:0]       full;
  logic [NPORT-1:0]       pick_ok;
  logic [NPORT*BI_W-1:0]  pick_bank;
  logic [NBANK-1:0]       set_en;
  logic [NBANK*TS_W-1:0]  set_ts;

  // route each winning port's timestamp to the bank it claimed
  always_comb begin
    set_en = '0;
    set_ts = '0;
    for (int b = 0; b < NBANK; b++) begin
      for (int p = 0; p < NPORT; p++) begin
        if (pick_ok[p] && pick_bank[p*BI_W +: BI_W] == BI_W'(b)) begin
          set_en[b]             = 1'b1;
          set_ts[b*TS_W +: TS_W] = req_ts[p*TS_W +: TS_W];
        end
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [NPORT-1:0] bhit;
    mm_bank_track #(.NPORT(NPORT), .TS_W(TS_W), .DEPTH(DEPTH)) trk_i (
      .clk    (clk),
      .rst    (rst),
      .q_ts   (req_ts),
      .hit    (bhit),
      .full   (full[b]),
      .set_en (set_en[b]),
      .set_ts (set_ts[b*TS_W +: TS_W]),
      .clr_en (dep_vld),
      .clr_ts (dep_ts)
    );
    for (genvar p = 0; p < NPORT; p++) begin : g_hit
      assign hit[p*NBANK + b] = bhit[p];
    end
  end

  mm_pick_chain #(.NPORT(NPORT), .NBANK(NBANK), .TS_W(TS_W), .BI_W(BI_W)) pick_i (
    .req_vld (req_vld),
    .req_ts  (req_ts),
    .hit     (hit),
    .full    (full),
    .dep_vld (dep_vld),
    .dep_ts  (dep_ts),
    .ok      (pick_ok),
    .bank    (pick_bank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_ok   <= '0;
      gnt_bank <= '0;
    end else begin
      gnt_ok   <= pick_ok;
      gnt_bank <= pick_bank;
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
      gnt_ok[i] |-> $past(req_vld[i]));
    assert_departing_refused_R9: assert property (@(posedge clk) disable iff (rst)
      ($past(req_vld[i]) && $past(dep_vld) &&
       $past(dep_ts) == $past(req_ts[i*TS_W +: TS_W])) |-> !gnt_ok[i]);
    for (genvar j = i + 1; j < NPORT; j++) begin : g_pair
      assert_no_shared_bank_R3: assert property (@(posedge clk) disable iff (rst)
        !(gnt_ok[i] && gnt_ok[j] &&
          gnt_bank[i*BI_W +: BI_W] == gnt_bank[j*BI_W +: BI_W]));
    end
  end
endmodule

// File: tb/mm_bank_picker_tb.sv
module mm_bank_picker_tb_top;
  localparam int NP = 5;
  localparam int NB = 5;
  localparam int TW = 4;
  localparam int DP = 4;
  localparam int BW = 3;
  localparam int NTS = 2 ** TW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NP-1:0]     req_vld = '0;
  logic [NP*TW-1:0]  req_ts = '0;
  logic              dep_vld = 1'b0;
  logic [TW-1:0]     dep_ts = '0;
  logic [NP-1:0]     gnt_ok;
  logic [NP*BW-1:0]  gnt_bank;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural model state
  int mocc [NB][NTS];
  int mcnt [NB];
  int exp_ok [NP];
  int exp_bank [NP];

  always #4 clk = ~clk;

  mm_bank_picker #(.NPORT(NP), .NBANK(NB), .TS_W(TW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_ts(req_ts),
    .dep_vld(dep_vld), .dep_ts(dep_ts), .gnt_ok(gnt_ok), .gnt_bank(gnt_bank));

  task automatic model_clear();
    for (int b = 0; b < NB; b++) begin
      mcnt[b] = 0;
      for (int t = 0; t < NTS; t++) mocc[b][t] = 0;
    end
  endtask

  // predict grants for the applied inputs, then advance the model table
  task automatic model_step(input int v[NP], input int t[NP], input int dv, input int dt);
    int used [NB];
    for (int b = 0; b < NB; b++) used[b] = 0;
    for (int p = 0; p < NP; p++) begin
      exp_ok[p] = 0;
      exp_bank[p] = 0;
      if (v[p] != 0 && !(dv != 0 && dt == t[p])) begin
        for (int b = 0; b < NB; b++) begin
          if (exp_ok[p] == 0 && used[b] == 0 && mocc[b][t[p]] == 0 && mcnt[b] < DP) begin
            exp_ok[p] = 1;
            exp_bank[p] = b;
            used[b] = 1;
          end
        end
      end
    end
    if (dv != 0) begin
      for (int b = 0; b < NB; b++) begin
        if (mocc[b][dt] != 0) begin
          mocc[b][dt] = 0;
          mcnt[b]--;
        end
      end
    end
    for (int p = 0; p < NP; p++) begin
      if (exp_ok[p] != 0) begin
        mocc[exp_bank[p]][t[p]] = 1;
        mcnt[exp_bank[p]]++;
      end
    end
  endtask

  task automatic check_outputs(input string tag);
    for (int p = 0; p < NP; p++) begin
      int aok;
      int abk;
      aok = int'(gnt_ok[p]);
      abk = int'(gnt_bank[p*BW +: BW]);
      total++;
      if (aok != exp_ok[p] || abk != exp_bank[p]) begin
        bad++;
        $display("FAIL %s port %0d: ok=%0d bank=%0d expected ok=%0d bank=%0d",
                 tag, p, aok, abk, exp_ok[p], exp_bank[p]);
      end
    end
    // R3: no two granted ports on one bank
    total++;
    for (int i = 0; i < NP; i++) begin
      for (int j = i + 1; j < NP; j++) begin
        if (gnt_ok[i] && gnt_ok[j] && gnt_bank[i*BW +: BW] == gnt_bank[j*BW +: BW]) begin
          bad++;
          $display("FAIL R3 ports %0d,%0d share bank: actual %0d expected distinct",
                   i, j, gnt_bank[i*BW +: BW]);
        end
      end
    end
  endtask

  task automatic step(input string tag, input int v[NP], input int t[NP], input int dv, input int dt);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      req_vld[p] = (v[p] != 0);
      req_ts[p*TW +: TW] = TW'(t[p]);
    end
    dep_vld = (dv != 0);
    dep_ts = TW'(dt);
    model_step(v, t, dv, dt);
    @(posedge clk);
    #1;
    check_outputs(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v[NP];
    int t[NP];
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    for (int p = 0; p < NP; p++) begin exp_ok[p] = 0; exp_bank[p] = 0; end
    check_outputs("R1 reset");
    @(negedge clk);
    rst = 1'b0;

    // R2: idle cycle
    v = '{0,0,0,0,0}; t = '{0,0,0,0,0};
    step("R2 idle", v, t, 0, 0);
    // R5: single request takes bank 0
    v = '{1,0,0,0,0}; t = '{3,0,0,0,0};
    step("R5 single", v, t, 0, 0);
    // R3/R5: five requests same timestamp spread over all banks
    v = '{1,1,1,1,1}; t = '{5,5,5,5,5};
    step("R3 R5 spread", v, t, 0, 0);
    // R4/R7: every bank now holds ts 5
    v = '{1,0,0,0,0}; t = '{5,0,0,0,0};
    step("R4 R7 clash", v, t, 0, 0);
    // R9: request for departing ts refused
    v = '{0,1,0,0,0}; t = '{0,5,0,0,0};
    step("R9 departing", v, t, 1, 5);
    // R8/R7: retry after departure succeeds on bank 0
    step("R8 R7 retry", v, t, 0, 0);
    // R5: lower port wins the lower bank
    v = '{1,0,1,0,0}; t = '{6,0,7,0,0};
    step("R5 priority", v, t, 0, 0);
    // R6: bank 0 holds 3,5,6; fill it with 8 then expect 9 to go to bank 1
    v = '{1,0,0,0,0}; t = '{8,0,0,0,0};
    step("R6 fill", v, t, 0, 0);
    t = '{9,0,0,0,0};
    step("R6 full skip", v, t, 0, 0);

    // random phase, narrow timestamps, sparse departures
    for (int c = 0; c < 3000; c++) begin
      int dv;
      for (int p = 0; p < NP; p++) begin
        v[p] = ($urandom_range(0, 3) != 0) ? 1 : 0;
        t[p] = int'($urandom_range(0, 5));
      end
      dv = ($urandom_range(0, 2) == 0) ? 1 : 0;
      step("R4 R6 R8 random", v, t, dv, int'($urandom_range(0, 5)));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule